// File: doc/BRIEF.md
# Concurrent Job Latency Counters

This block measures the timing of a processing pipeline that keeps several jobs in flight at once. A start pulse marks the cycle in which a job's first descriptor word is taken. A finish pulse marks the cycle just before that job's completion is announced. From these two pulses the block keeps a running count of the jobs that are active. It uses that count to advance two 64-bit counters on every clock. The busy counter adds one in each cycle where at least one job is active, so it gives the wall-clock time the pipeline was occupied. The summed-latency counter adds the number of active jobs, so it gives the total latency of all jobs taken together. A third counter holds the number of completed jobs.

Software reads all three through a 32-bit register port with byte addresses. It divides the summed latency by the completion count to get the average latency of one job. The two halves of a 64-bit counter are separate reads that are not captured together. Software should therefore read them only while the pipeline is idle. A parameter sets the largest number of jobs that may be in flight at once. A start that arrives when that limit is reached is dropped and flagged on an output pin.

Top module: `job_latency_counters`

## Requirements
- R1: After reset, every readable register reads zero, `active_jobs` is zero and `start_drop` is low.
- R2: An accepted start raises `active_jobs` by one after the next clock edge, and an accepted finish lowers it by one. A start and a finish accepted at the same edge leave it unchanged.
- R3: At every clock edge, the busy counter (lower half at byte address 0x00, upper half at 0x04) adds 1 if `active_jobs` was nonzero before that edge, and otherwise holds.
- R4: At every clock edge, the summed-latency counter (lower half at 0x08, upper half at 0x0C) adds the value `active_jobs` had before that edge.
- R5: A lone job whose start is sampled at edge a and whose finish is sampled at edge b adds b−a to both the busy and the summed-latency counters, and adds 1 to the completion count.
- R6: The completion count at byte address 0x10 adds one for each accepted finish.
- R7: A start is dropped when `active_jobs` equals MAX_JOBS and no finish arrives in the same cycle. In that cycle `start_drop` is high, and `active_jobs` does not change. A start together with a finish while at the limit is accepted, and `start_drop` stays low.
- R8: A finish while `active_jobs` is zero is ignored. The completion count and `active_jobs` stay unchanged.
- R9: A read strobe returns data on `csr_rdata` with `csr_rvalid` high one cycle later. Any address other than 0x00, 0x04, 0x08, 0x0C or 0x10, including addresses that are not word-aligned, reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Pulse: a job's first descriptor word was taken |
| job_finish | input | 1 | Pulse: a job finishes; its completion is announced next |
| active_jobs | output | $clog2(MAX_JOBS+1) | Number of jobs currently in flight |
| start_drop | output | 1 | High in a cycle whose start is dropped at the limit |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Byte address of the read |
| csr_rdata | output | DATA_W | Read data, registered |
| csr_rvalid | output | 1 | High in the cycle after a read strobe |

## Verification
The bound checker covers the rules that hold on every cycle. It checks how much the busy, summed-latency and completion counters move at each edge, given the job count before that edge. It also checks that the job count never exceeds the limit, that a drop happens only at the limit with no finish, that a start and a finish together hold the count steady, and that a finish while idle changes nothing.

Some behaviour can only be shown by the bench's scenarios. These are the register map and the zero returned from unmapped and unaligned addresses. Others are the end-to-end latency totals for one job and for overlapping jobs, and the reset state as software sees it.

// File: rtl/job_latency_counters.sv
module job_latency_counters #(
  parameter int MAX_JOBS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          job_start,
  input  logic                          job_finish,
  output logic [$clog2(MAX_JOBS+1)-1:0] active_jobs,
  output logic                          start_drop,
  input  logic                          csr_rd,
  input  logic [ADDR_W-1:0]             csr_addr,
  output logic [DATA_W-1:0]             csr_rdata,
  output logic                          csr_rvalid
);

  localparam int JW = $clog2(MAX_JOBS + 1);
  localparam int CW = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] OFS_BUSY_LO = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_BUSY_HI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_SUM_LO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_SUM_HI  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_DONE    = ADDR_W'(8'h10);

  logic [JW-1:0]     jobs_q;
  logic [CW-1:0]     busy_q;
  logic [CW-1:0]     sum_q;
  logic [DATA_W-1:0] done_q;
  logic [DATA_W-1:0] rd_mux;

  wire at_limit = (jobs_q == JW'(MAX_JOBS));
  wire fin_ok   = job_finish && (jobs_q != '0);
  wire take     = job_start && (!at_limit || fin_ok);

  assign start_drop  = job_start && !take;
  assign active_jobs = jobs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jobs_q <= '0;
      busy_q <= '0;
      sum_q  <= '0;
      done_q <= '0;
    end else begin
      busy_q <= busy_q + CW'(jobs_q != '0);
      sum_q  <= sum_q + CW'(jobs_q);
      done_q <= done_q + DATA_W'(fin_ok);
      case ({take, fin_ok})
        2'b10:   jobs_q <= jobs_q + 1'b1;
        2'b01:   jobs_q <= jobs_q - 1'b1;
        default: jobs_q <= jobs_q;
      endcase
    end
  end

  always_comb begin
    case (csr_addr)
      OFS_BUSY_LO: rd_mux = busy_q[DATA_W-1:0];
      OFS_BUSY_HI: rd_mux = busy_q[CW-1:DATA_W];
      OFS_SUM_LO:  rd_mux = sum_q[DATA_W-1:0];
      OFS_SUM_HI:  rd_mux = sum_q[CW-1:DATA_W];
      OFS_DONE:    rd_mux = done_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rdata  <= '0;
      csr_rvalid <= 1'b0;
    end else begin
      csr_rvalid <= csr_rd;
      if (csr_rd) csr_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/job_latency_counters_chk.sv
module job_latency_counters_chk #(
  parameter int MAX_JOBS = 8,
  parameter int DATA_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          job_start,
  input logic                          job_finish,
  input logic                          start_drop,
  input logic [$clog2(MAX_JOBS+1)-1:0] jobs,
  input logic [2*DATA_W-1:0]           busy,
  input logic [2*DATA_W-1:0]           sum,
  input logic [DATA_W-1:0]             done,
  input logic                          csr_rd,
  input logic                          csr_rvalid
);
  localparam int JW = $clog2(MAX_JOBS + 1);
  localparam int CW = 2 * DATA_W;

  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy == $past(busy) + CW'($past(jobs) != '0)); // R3
  AST_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sum == $past(sum) + CW'($past(jobs))); // R4
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(done) + DATA_W'($past(job_finish) && ($past(jobs) != '0))); // R6
  AST_JOBS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    jobs <= JW'(MAX_JOBS)); // R7
  AST_DROP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |-> (jobs == JW'(MAX_JOBS)) && !job_finish); // R7
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> $stable(jobs)); // R7
  AST_START_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (job_start && !job_finish && jobs < JW'(MAX_JOBS)) |=> jobs == $past(jobs) + 1'b1); // R2
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (job_start && job_finish && jobs != '0) |=> $stable(jobs)); // R2
  AST_IDLE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (job_finish && !job_start && jobs == '0) |=> (jobs == '0) && $stable(done)); // R8
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> csr_rvalid); // R9
endmodule

bind job_latency_counters job_latency_counters_chk #(
  .MAX_JOBS(MAX_JOBS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_finish(job_finish),
  .start_drop(start_drop), .jobs(jobs_q), .busy(busy_q), .sum(sum_q),
  .done(done_q), .csr_rd(csr_rd), .csr_rvalid(csr_rvalid)
);

// File: tb/job_latency_counters_test.sv
module job_latency_counters_test;
  localparam int MAXJ = 8;
  localparam int JW   = $clog2(MAXJ + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_start = 1'b0, job_finish = 1'b0, csr_rd = 1'b0;
  logic [10:0] csr_addr = '0;
  logic [JW-1:0] active_jobs;
  logic start_drop, csr_rvalid;
  logic [31:0] csr_rdata;

  int checks = 0, fails = 0;
  logic [63:0] m_busy, m_sum;
  logic [31:0] m_done;
  int m_jobs;

  job_latency_counters #(.MAX_JOBS(MAXJ)) uut (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_finish(job_finish),
    .active_jobs(active_jobs), .start_drop(start_drop), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sum = 0; m_done = 0; m_jobs = 0;
    end else begin
      bit f, s;
      m_busy = m_busy + ((m_jobs != 0) ? 64'd1 : 64'd0);
      m_sum  = m_sum + 64'(m_jobs);
      f = job_finish && (m_jobs != 0);
      s = job_start && ((m_jobs < MAXJ) || f);
      if (f) m_done = m_done + 1;
      m_jobs = m_jobs + int'(s) - int'(f);
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic s, input logic f);
    job_start = s; job_finish = f;
    @(negedge clk);
    job_start = 1'b0; job_finish = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    chk("R9", "rvalid", 64'(csr_rvalid), 64'd1);
    d = csr_rdata;
  endtask

  task automatic rd64(input logic [10:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 11'd4, hi);
    v = {hi, lo};
  endtask

  task automatic snap(output logic [63:0] b, output logic [63:0] s, output logic [31:0] d);
    rd64(11'h00, b); rd64(11'h08, s); rd(11'h10, d);
  endtask

  task automatic match_model(input string req);
    logic [63:0] b, s; logic [31:0] d;
    snap(b, s, d);
    chk(req, "busy vs model", b, m_busy);
    chk(req, "sum vs model", s, m_sum);
    chk(req, "done vs model", 64'(d), 64'(m_done));
    chk(req, "active_jobs vs model", 64'(active_jobs), 64'(m_jobs));
  endtask

  task automatic t_reset;
    logic [63:0] b, s; logic [31:0] d;
    snap(b, s, d);
    chk("R1", "busy", b, 0);
    chk("R1", "sum", s, 0);
    chk("R1", "done", 64'(d), 0);
    chk("R1", "active_jobs", 64'(active_jobs), 0);
    chk("R1", "start_drop", 64'(start_drop), 0);
  endtask

  task automatic t_single;
    logic [63:0] b0, s0, b1, s1; logic [31:0] d0, d1;
    snap(b0, s0, d0);
    step(1'b1, 1'b0);
    chk("R2", "count after start", 64'(active_jobs), 1);
    idle(4);
    step(1'b0, 1'b1);
    chk("R2", "count after finish", 64'(active_jobs), 0);
    snap(b1, s1, d1);
    chk("R5", "busy delta", b1 - b0, 5);
    chk("R5", "sum delta", s1 - s0, 5);
    chk("R5", "done delta", 64'(d1 - d0), 1);
  endtask

  task automatic t_overlap;
    logic [63:0] b0, s0, b1, s1; logic [31:0] d0, d1;
    snap(b0, s0, d0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R2", "two in flight", 64'(active_jobs), 2);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    snap(b1, s1, d1);
    chk("R3", "busy counts overlap once", b1 - b0, 5);
    chk("R4", "sum counts each job", s1 - s0, 6);
    chk("R6", "two completions", 64'(d1 - d0), 2);
  endtask

  task automatic t_same_cycle;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R2", "start+finish holds", 64'(active_jobs), 1);
    step(1'b0, 1'b1);
    match_model("R2");
  endtask

  task automatic t_limit;
    for (int i = 0; i < MAXJ; i++) step(1'b1, 1'b0);
    chk("R7", "filled", 64'(active_jobs), MAXJ);
    job_start = 1'b1;
    #1 chk("R7", "drop flagged", 64'(start_drop), 1);
    @(negedge clk); job_start = 1'b0;
    chk("R7", "count held at limit", 64'(active_jobs), MAXJ);
    job_start = 1'b1; job_finish = 1'b1;
    #1 chk("R7", "no drop with finish", 64'(start_drop), 0);
    @(negedge clk); job_start = 1'b0; job_finish = 1'b0;
    chk("R7", "count after swap", 64'(active_jobs), MAXJ);
    for (int i = 0; i < MAXJ; i++) step(1'b0, 1'b1);
    match_model("R4");
  endtask

  task automatic t_idle_finish;
    logic [31:0] d0, d1;
    rd(11'h10, d0);
    step(1'b0, 1'b1);
    chk("R8", "count stays zero", 64'(active_jobs), 0);
    rd(11'h10, d1);
    chk("R8", "done unchanged", 64'(d1), 64'(d0));
  endtask

  task automatic t_map;
    logic [31:0] d;
    rd(11'h02, d); chk("R9", "unaligned reads zero", 64'(d), 0);
    rd(11'h14, d); chk("R9", "unmapped reads zero", 64'(d), 0);
    rd(11'h7FC, d); chk("R9", "top reads zero", 64'(d), 0);
    @(negedge clk);
    chk("R9", "rvalid idle", 64'(csr_rvalid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_overlap();
    t_same_cycle();
    t_limit();
    t_idle_finish();
    t_map();
    match_model("R3");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule